// File: doc/BRIEF.md
# Ethernet PHY Front-Panel Status LED Driver

This block turns the internal status of a 10/100 Ethernet transceiver into the levels that drive its front-panel indicator pins. It has one output for each status item: link, 100 Mb/s speed, 10 Mb/s speed, duplex, transmit activity, receive activity and collision. Static status is shown as a steady level. The link indicator changes its sense with the interface mode: the nibble-wide MII, the 7-wire serial interface, or symbol bypass. Most outputs are active low. The link output in serial mode is the exception and is active high.

A single activity, receive or collision event may last only one clock. The block stretches each such event into a visible burst: while the burst lasts, the output blinks at a fixed rate, and each new event starts the burst length again. Collision events are only honoured in half duplex. A strap sampled while reset is held selects the one-LED-per-function mapping this block implements. If the strap selects the other mapping, which lives outside this block, every output here stays at its off level.

Top module: `phy_led_drv`

## Requirements
- R1: While reset (`rst_n` low) is asserted, every LED output is high.
- R2: With `if_mode` 0 (MII) or 3 (treated as MII), `led_link` is low when `link_up` is 1 and high when `link_up` is 0.
- R3: With `if_mode` 1 (7-wire serial), `led_link` is high when `link_up` is 1 and low when `link_up` is 0.
- R4: With `if_mode` 2 (symbol bypass), `led_link` is high whatever `link_up` is.
- R5: `led_spd100` is low when `speed_100` is 1 and high when it is 0. `led_spd10` is always the opposite of `led_spd100`.
- R6: `led_dpx` is low when `full_duplex` is 1 and high when it is 0.
- R7: The link, speed and duplex outputs follow their inputs exactly one clock later.
- R8: If an event arrives while an activity output is idle, that output goes low on the next clock. It then inverts after every BLINK_CYC further clocks while the burst lasts.
- R9: Every event restarts the burst. The output returns high, and stays high, exactly STRETCH_CYC clocks after the clock that sampled the last event.
- R10: `col_evt` starts or extends a collision burst only while `full_duplex` is 0. While `full_duplex` is 1, `led_col` is high in the same cycle.
- R11: `strap_std` is sampled on every clock while reset is held. If it was 0, every output stays high until the next reset, whatever the other inputs do.
- R12: The transmit, receive and collision outputs are driven by separate stretchers. An event on one input does not affect the other two outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_std | input | 1 | Mapping strap: 1 selects the standard mapping |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| if_mode | input | 2 | 0 MII, 1 7-wire serial, 2 symbol bypass, 3 as MII |
| tx_act | input | 1 | Transmit activity event |
| rx_act | input | 1 | Receive activity event |
| col_evt | input | 1 | Collision event |
| led_link | output | 1 | Link indicator |
| led_spd100 | output | 1 | 100 Mb/s indicator, active low |
| led_spd10 | output | 1 | 10 Mb/s indicator, active low |
| led_dpx | output | 1 | Duplex indicator, low for full duplex |
| led_tx | output | 1 | Transmit activity, blinking |
| led_rx | output | 1 | Receive activity, blinking |
| led_col | output | 1 | Collision, blinking in half duplex |

## Verification
The default parameters give a burst of about 50 ms, which is far too long to simulate. The bench therefore builds the block with STRETCH_CYC = 20 and BLINK_CYC = 3. With these values a burst holds about three blink periods, so an event that lands on the final count, a burst that ends exactly on time, and restarts in the middle of a blink period all occur many times within a few thousand random cycles. A blink period of 3 is odd, so it also separates the toggle timing from the stretch count.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

   typedef enum logic [1:0] {
      IFM_MII    = 2'd0,
      IFM_SERIAL = 2'd1,
      IFM_BYPASS = 2'd2,
      IFM_RSVD   = 2'd3
   } if_mode_t;

   localparam int unsigned NUM_ACT = 3;
   localparam int unsigned ACT_TX  = 0;
   localparam int unsigned ACT_RX  = 1;
   localparam int unsigned ACT_COL = 2;

   localparam logic LED_OFF = 1'b1;

endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int unsigned STRETCH_CYC = 2_500_000,
   parameter int unsigned BLINK_CYC   = 250_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   output logic led
);
   localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
   localparam int unsigned BW = $clog2(BLINK_CYC);
   localparam logic [CW-1:0] C_LOAD = CW'(STRETCH_CYC);
   localparam logic [BW-1:0] B_LAST = BW'(BLINK_CYC - 1);

   logic [CW-1:0] remain_q;
   logic [BW-1:0] phase_q;
   logic          active;

   assign active = (remain_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         phase_q  <= '0;
         led      <= phy_led_pkg::LED_OFF;
      end else if (evt) begin
         remain_q <= C_LOAD;
         if (!active) begin
            led     <= ~phy_led_pkg::LED_OFF;
            phase_q <= '0;
         end else if (phase_q == B_LAST) begin
            led     <= ~led;
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end else if (active) begin
         remain_q <= remain_q - 1'b1;
         if (remain_q == CW'(1)) begin
            led     <= phy_led_pkg::LED_OFF;
            phase_q <= '0;
         end else if (phase_q == B_LAST) begin
            led     <= ~led;
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/led_status.sv
module led_status
   import phy_led_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  if_mode_t mode,
   input  logic     link_up,
   input  logic     speed_100,
   input  logic     full_duplex,
   output logic     led_link,
   output logic     led_spd100,
   output logic     led_spd10,
   output logic     led_dpx
);
   logic link_nxt;

   always_comb begin
      unique case (mode)
         IFM_SERIAL: link_nxt = link_up;
         IFM_BYPASS: link_nxt = 1'b1;
         default:    link_nxt = ~link_up;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_link   <= LED_OFF;
         led_spd100 <= LED_OFF;
         led_spd10  <= LED_OFF;
         led_dpx    <= LED_OFF;
      end else begin
         led_link   <= link_nxt;
         led_spd100 <= ~speed_100;
         led_spd10  <= speed_100;
         led_dpx    <= ~full_duplex;
      end
   end
endmodule

// File: rtl/phy_led_drv.sv
module phy_led_drv
   import phy_led_pkg::*;
#(
   parameter int unsigned STRETCH_CYC = 2_500_000,
   parameter int unsigned BLINK_CYC   = 250_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_std,
   input  logic       link_up,
   input  logic       speed_100,
   input  logic       full_duplex,
   input  logic [1:0] if_mode,
   input  logic       tx_act,
   input  logic       rx_act,
   input  logic       col_evt,
   output logic       led_link,
   output logic       led_spd100,
   output logic       led_spd10,
   output logic       led_dpx,
   output logic       led_tx,
   output logic       led_rx,
   output logic       led_col
);
   if (BLINK_CYC < 2) begin : g_bad_blink
      $error("BLINK_CYC must be at least 2");
   end
   if (STRETCH_CYC <= BLINK_CYC) begin : g_bad_stretch
      $error("STRETCH_CYC must exceed BLINK_CYC");
   end

   logic               std_sel;
   logic [NUM_ACT-1:0] act_evt;
   logic [NUM_ACT-1:0] act_led;
   logic               s_link, s_spd100, s_spd10, s_dpx;

   always_ff @(posedge clk) begin
      if (!rst_n) std_sel <= strap_std;
   end

   assign act_evt[ACT_TX]  = tx_act;
   assign act_evt[ACT_RX]  = rx_act;
   assign act_evt[ACT_COL] = col_evt & ~full_duplex;

   for (genvar g = 0; g < NUM_ACT; g++) begin : g_act
      led_stretch #(
         .STRETCH_CYC (STRETCH_CYC),
         .BLINK_CYC   (BLINK_CYC)
      ) u_str (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (act_evt[g]),
         .led   (act_led[g])
      );
   end

   led_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (if_mode_t'(if_mode)),
      .link_up     (link_up),
      .speed_100   (speed_100),
      .full_duplex (full_duplex),
      .led_link    (s_link),
      .led_spd100  (s_spd100),
      .led_spd10   (s_spd10),
      .led_dpx     (s_dpx)
   );

   logic gate_off;
   assign gate_off = ~rst_n | ~std_sel;

   assign led_link   = gate_off | s_link;
   assign led_spd100 = gate_off | s_spd100;
   assign led_spd10  = gate_off | s_spd10;
   assign led_dpx    = gate_off | s_dpx;
   assign led_tx     = gate_off | act_led[ACT_TX];
   assign led_rx     = gate_off | act_led[ACT_RX];
   assign led_col    = gate_off | full_duplex | act_led[ACT_COL];
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       std_sel,
   input logic       link_up,
   input logic       full_duplex,
   input logic [1:0] if_mode,
   input logic       led_link,
   input logic       led_spd100,
   input logic       led_spd10,
   input logic       led_dpx,
   input logic       led_tx,
   input logic       led_rx,
   input logic       led_col
);
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_off_R1: assert (led_link && led_spd100 && led_spd10 && led_dpx
                                      && led_tx && led_rx && led_col);
      end
   end

   assert_bypass_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (if_mode == 2'd2) |=> led_link);

   assert_serial_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (std_sel && if_mode == 2'd1 && link_up) |=> led_link);

   assert_mii_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (std_sel && if_mode == 2'd0 && link_up) |=> !led_link);

   assert_speed_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      std_sel |=> (led_spd10 != led_spd100));

   assert_fdx_col_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      full_duplex |-> led_col);

   assert_strap_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !std_sel |-> (led_link && led_dpx && led_tx && led_rx && led_col));
endmodule

bind phy_led_drv phy_led_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .std_sel     (std_sel),
   .link_up     (link_up),
   .full_duplex (full_duplex),
   .if_mode     (if_mode),
   .led_link    (led_link),
   .led_spd100  (led_spd100),
   .led_spd10   (led_spd10),
   .led_dpx     (led_dpx),
   .led_tx      (led_tx),
   .led_rx      (led_rx),
   .led_col     (led_col)
);

// File: tb/test_phy_led_drv.sv
module test_phy_led_drv;
   localparam int STR = 20;
   localparam int BLK = 3;

   logic clk = 0, rst_n = 0, strap_std = 1;
   logic link_up = 0, speed_100 = 0, full_duplex = 0;
   logic [1:0] if_mode = 0;
   logic tx_act = 0, rx_act = 0, col_evt = 0;
   logic led_link, led_spd100, led_spd10, led_dpx, led_tx, led_rx, led_col;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   phy_led_drv #(.STRETCH_CYC(STR), .BLINK_CYC(BLK)) i_phy_led_drv (
      .clk(clk), .rst_n(rst_n), .strap_std(strap_std), .link_up(link_up),
      .speed_100(speed_100), .full_duplex(full_duplex), .if_mode(if_mode),
      .tx_act(tx_act), .rx_act(rx_act), .col_evt(col_evt),
      .led_link(led_link), .led_spd100(led_spd100), .led_spd10(led_spd10),
      .led_dpx(led_dpx), .led_tx(led_tx), .led_rx(led_rx), .led_col(led_col));

   // reference model: burst tracked as steps since start and clocks left
   logic e_std;
   logic e_link = 1, e_s100 = 1, e_s10 = 1, e_dpx = 1;
   bit   m_on[3];
   int   m_steps[3];
   int   m_left[3];

   function automatic logic link_exp(logic [1:0] m, logic up);
      if (m == 2'd1) return up;
      if (m == 2'd2) return 1'b1;
      return !up;
   endfunction

   function automatic logic burst_led(bit on, int steps);
      if (!on) return 1'b1;
      return ((steps / BLK) % 2) != 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin m_on[i] = 0; m_steps[i] = 0; m_left[i] = 0; end
         e_link = 1; e_s100 = 1; e_s10 = 1; e_dpx = 1;
      end else begin
         logic ev[3];
         ev[0] = tx_act; ev[1] = rx_act; ev[2] = col_evt && !full_duplex;
         for (int i = 0; i < 3; i++) begin
            if (ev[i]) begin
               if (!m_on[i]) begin m_on[i] = 1; m_steps[i] = 0; end
               else m_steps[i]++;
               m_left[i] = STR;
            end else if (m_on[i]) begin
               if (m_left[i] == 1) m_on[i] = 0;
               else begin m_left[i]--; m_steps[i]++; end
            end
         end
         e_link = link_exp(if_mode, link_up);
         e_s100 = !speed_100; e_s10 = speed_100; e_dpx = !full_duplex;
      end
   end
   always @(posedge clk) if (!rst_n) e_std = strap_std;

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic g = !e_std;
      string lt = (if_mode == 2'd1) ? "R3 link serial" :
                  (if_mode == 2'd2) ? "R4 link bypass" : "R2 R7 link MII";
      if (g) lt = "R11 strap off link";
      chk(lt, led_link, g | e_link);
      chk(g ? "R11 spd100" : "R5 R7 spd100", led_spd100, g | e_s100);
      chk(g ? "R11 spd10" : "R5 spd10", led_spd10, g | e_s10);
      chk(g ? "R11 dpx" : "R6 dpx", led_dpx, g | e_dpx);
      chk(g ? "R11 tx" : "R8 R9 tx", led_tx, g | burst_led(m_on[0], m_steps[0]));
      chk(g ? "R11 rx" : "R12 rx", led_rx, g | burst_led(m_on[1], m_steps[1]));
      chk(g ? "R11 col" : "R10 col", led_col,
          g | full_duplex | burst_led(m_on[2], m_steps[2]));
   endtask

   task automatic step();
      @(negedge clk);
      if (rst_n) check_all();
   endtask

   task automatic do_reset(logic s);
      @(negedge clk);
      rst_n = 0; strap_std = s;
      repeat (3) begin
         @(negedge clk);
         // R1: all outputs off while reset held
         chk("R1 reset", {led_link, led_spd100, led_spd10, led_dpx, led_tx, led_rx, led_col} == 7'h7f, 1'b1);
      end
      rst_n = 1;
   endtask

   task automatic randomize_inputs(int act_div);
      if ($urandom_range(7) == 0) link_up = $urandom_range(1);
      if ($urandom_range(15) == 0) speed_100 = $urandom_range(1);
      if ($urandom_range(15) == 0) full_duplex = $urandom_range(1);
      if ($urandom_range(15) == 0) if_mode = 2'($urandom_range(3));
      tx_act  = ($urandom_range(act_div) == 0);
      rx_act  = ($urandom_range(act_div) == 0);
      col_evt = ($urandom_range(act_div) == 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1ed5));
      do_reset(1'b1);
      // directed: single transmit event, burst and exact expiry (R8, R9)
      @(negedge clk); tx_act = 1;
      @(negedge clk); tx_act = 0; check_all();
      chk("R8 tx on after event", led_tx, 1'b0);
      repeat (STR + 4) step();
      chk("R9 tx off after stretch", led_tx, 1'b1);
      // directed: restart mid-burst, rx only (R9, R12)
      rx_act = 1; step(); rx_act = 0;
      repeat (10) step();
      rx_act = 1; step(); rx_act = 0;
      chk("R12 tx untouched by rx", led_tx, 1'b1);
      repeat (STR + 2) step();
      // directed: collision in full duplex ignored (R10)
      full_duplex = 1; col_evt = 1; step(); col_evt = 0;
      full_duplex = 0; step();
      chk("R10 col ignored in fdx", led_col, 1'b1);
      // directed: every mode with link up and down (R2 R3 R4)
      for (int m = 0; m < 4; m++) begin
         if_mode = 2'(m); link_up = 1; step(); step();
         link_up = 0; step(); step();
      end
      // random phase
      for (int k = 0; k < 4000; k++) begin
         randomize_inputs((k < 2000) ? 15 : 40);
         step();
      end
      tx_act = 0; rx_act = 0; col_evt = 0;
      // strap low: everything held off (R11)
      do_reset(1'b0);
      for (int k = 0; k < 300; k++) begin
         randomize_inputs(4);
         step();
      end
      do_reset(1'b1);
      for (int k = 0; k < 300; k++) begin
         randomize_inputs(10);
         step();
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule